// File: doc/BRIEF.md
# Bridge Configuration Space Register File

This block holds the configuration registers of a PCI-to-PCI bridge acting as a root port. It covers the 64-byte type-1 header. When a parameter enables it, a PCI Express capability structure of 15 dwords follows at byte offset 0x40. Every bit of every dword has one attribute: read-only, read-write, write-one-to-clear, or reserved. Reads pass only the bits that carry an attribute, so a reserved bit always reads 0. Writes change only the read-write bits and the write-one-to-clear bits, and only inside the byte lanes that the access covers.

Requests arrive on a single strobe. Each carries a byte offset, an access size of 1, 2 or 4 bytes, a direction and write data. One clock later the block returns a response pulse with read data and an error flag. A second input lets the surrounding hardware raise status events: it sets write-one-to-clear bits in a chosen dword, and software later clears them. Identity values come from parameters. Two further parameters change some attributes: one enables the capability, and one removes the prefetchable window.

Top module: `bridge_cfg_regs`

## Requirements
- R1: After reset, dword 0x00 reads {DEVICE_ID, VENDOR_ID}, dword 0x04 reads 0x00100000 (capability-list status bit 20 set), dword 0x08 reads {24'h060400, REV_ID}, and dword 0x0C reads 0x00010010 (header type 0x01 in bits 23:16, cache line size 0x10 in bits 7:0).
- R2: `resp_valid` rises exactly one clock after a clock with `req_valid` high. `resp_data` and `resp_err` are valid in that same cycle. With no request, the next cycle shows `resp_valid`, `resp_err` and `resp_data` all at 0.
- R3: A read returns the stored dword ANDed with the union of its read-only, read-write and write-one-to-clear masks. For example, with the capability enabled, writing all ones to 0x3C reads back 0x004F00FF.
- R4: A 1-byte read returns the dword shifted right by 8*(offset mod 4) and masked to 8 bits. A 2-byte read uses the same shift with a 16-bit mask.
- R5: A write touches only the byte lanes selected by its size and offset[1:0]. Its data sits in the low bits of `req_wdata` and is shifted left by 8*(offset mod 4).
- R6: In the bus-number dword (0x18), bits 23:0 are read-write and bits 31:24 are read-only. In the I/O base/limit half (0x1C bits 15:0), the upper nibble of each byte is read-write and the lower nibble is read-only.
- R7: A write-one-to-clear bit is cleared only by a write that covers its lane with a 1 in that bit position. A 0, or a lane outside the access, leaves the bit unchanged. The status error bits are bits 31:27 and 24 of dwords 0x04 and 0x1C.
- R8: The status-set input sets only the write-one-to-clear bits of the dword it selects. If a clearing write to the same bit happens in the same cycle, the set wins.
- R9: An in-range access whose size is not 1, 2 or 4 returns `resp_err`=1 with data 0 and changes no state. A valid size returns `resp_err`=0.
- R10: Accesses at or above the end of the space (0x40 without the capability, 0x7C with it) read 0, report no error and change nothing.
- R11: With the capability enabled, 0x34 reads 0x40 and dword 0x40 reads 0x00420010 (ID 0x10, version 2, root-port type 4 in bits 23:20). Without the capability, 0x34 reads 0.
- R12: The memory window dword 0x20 and the prefetchable window dword 0x24 have bits 31:20 and 15:4 read-write. With NO_PREF set, all of 0x24 is read-only with value 0, while the upper-32 dword 0x28 stays fully read-write.
- R13: Without the capability, bridge-control bit 26 of dword 0x3C is write-one-to-clear and read-write bits 0x0B6F00FF are writable. With the capability, bit 26 is reserved and the read-write set narrows to 0x004F00FF.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, one cycle per access |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_offset | input | OFS_W | Byte offset into configuration space |
| req_size | input | 3 | Access size in bytes (1, 2 or 4 valid) |
| req_wdata | input | 32 | Write data, right-aligned |
| sts_set_en | input | 1 | Status event strobe from hardware |
| sts_set_dw | input | OFS_W-2 | Dword index for the status event |
| sts_set_bits | input | 32 | Bits to raise (filtered to write-one-to-clear) |
| resp_valid | output | 1 | Response pulse, one clock after a request |
| resp_err | output | 1 | Bad access size |
| resp_data | output | 32 | Read data, right-aligned |

## Verification
The bench builds two copies side by side. The first has the capability on and the prefetchable window present. The second has the capability off and NO_PREF set. Between them, both range limits and both attribute sets for the bridge-control and command dwords can be exercised, along with the read-only prefetchable window. The tests run on each copy in the same run. Directed sequences then raise status bits through the event input, attempt clears with zero data and with lanes that miss the bits, and collide a set with a clear in one cycle.

// File: rtl/bridge_cfg_pkg.sv
package bridge_cfg_pkg;

  localparam int DATA_W     = 32;
  localparam int HDR_DWORDS = 16;
  localparam int CAP_DWORDS = 15;

  typedef struct packed {
    logic [DATA_W-1:0] ro;
    logic [DATA_W-1:0] rw;
    logic [DATA_W-1:0] w1c;
  } attr_t;

  // Per-dword bit attributes; idx counts dwords from offset 0.
  function automatic attr_t attr_of(int idx, bit pcie, bit nopref);
    attr_t a;
    a = '0;
    if (!pcie && idx >= HDR_DWORDS) return a;
    case (idx)
      0, 2, 4, 5, 14: a.ro = '1;
      1: begin
        a.rw  = 32'h0000_0147;
        a.ro  = pcie ? 32'h0010_0000 : 32'h06B0_02B8;
        a.w1c = 32'hF900_0000;
      end
      3:  a.ro = pcie ? 32'hFFFF_00FF : 32'hFFFF_FFFF;
      6: begin
        a.rw = 32'h00FF_FFFF;
        a.ro = pcie ? 32'h0000_0000 : 32'hFF00_0000;
      end
      7: begin
        a.rw  = 32'h0000_F0F0;
        a.ro  = pcie ? 32'h0000_0F0F : 32'h06A0_0F0F;
        a.w1c = 32'hF900_0000;
      end
      8: begin
        a.rw = 32'hFFF0_FFF0;
        a.ro = 32'h000F_000F;
      end
      9: begin
        if (nopref) a.ro = '1;
        else begin
          a.rw = 32'hFFF0_FFF0;
          a.ro = 32'h000F_000F;
        end
      end
      10, 11, 12: a.rw = '1;
      13: a.ro = 32'h0000_00FF;
      15: begin
        a.rw  = pcie ? 32'h004F_00FF : 32'h0B6F_00FF;
        a.ro  = pcie ? 32'h0000_FF00 : 32'h0080_FF00;
        a.w1c = pcie ? 32'h0000_0000 : 32'h0400_0000;
      end
      // capability structure, dword 16 = offset 0x40
      16: a.ro = 32'h7FFF_FFFF;
      17: a.ro = 32'h0000_803F;
      18: begin
        a.rw  = 32'h0000_7FFF;
        a.w1c = 32'h000F_0000;
        a.ro  = 32'h0030_0000;
      end
      19: a.ro = 32'hFF7B_FFFF;
      20: begin
        a.rw  = 32'h0000_CEFB;
        a.ro  = 32'h3FFF_0000;
        a.w1c = 32'hC000_0000;
      end
      21: a.ro = '1;
      22: begin
        a.rw  = 32'h0000_7FFF;
        a.w1c = 32'h011F_0000;
        a.ro  = 32'h00E0_0000;
      end
      23: begin
        a.rw = 32'h0000_001F;
        a.ro = 32'h0001_0000;
      end
      24: begin
        a.ro  = 32'h0002_FFFF;
        a.w1c = 32'h0001_0000;
      end
      25: a.ro = 32'h80FF_FFFF;
      26: a.rw = 32'h0000_F7FF;
      27: a.ro = 32'h81FF_FFFE;
      28: begin
        a.rw  = 32'h0000_FFFF;
        a.w1c = 32'h8020_0000;
        a.ro  = 32'h73DF_0000;
      end
      default: a = '0;
    endcase
    return a;
  endfunction

  // Reset contents of each dword.
  function automatic logic [DATA_W-1:0] init_of(int idx, bit pcie,
                                                logic [15:0] vid,
                                                logic [15:0] did,
                                                logic [7:0]  rev);
    case (idx)
      0:       return {did, vid};
      1:       return 32'h0010_0000;
      2:       return {24'h060400, rev};
      3:       return 32'h0001_0010;
      13:      return pcie ? 32'h0000_0040 : 32'h0;
      16:      return pcie ? 32'h0042_0010 : 32'h0;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/bridge_cfg_attr.sv
module bridge_cfg_attr
  import bridge_cfg_pkg::*;
#(
  parameter int IDX_W   = 6,
  parameter int DW_N    = 31,
  parameter bit PCIE_EN = 1'b1,
  parameter bit NO_PREF = 1'b0
) (
  input  logic [IDX_W-1:0] sel_idx,
  output attr_t            sel_attr,
  output attr_t            tbl [DW_N]
);

  for (genvar g = 0; g < DW_N; g++) begin : g_tbl
    assign tbl[g] = attr_of(g, PCIE_EN, NO_PREF);
  end

  always_comb begin
    sel_attr = '0;
    for (int i = 0; i < DW_N; i++) begin
      if (sel_idx == IDX_W'(i)) sel_attr = tbl[i];
    end
  end

endmodule

// File: rtl/bridge_cfg_lane.sv
module bridge_cfg_lane #(
  parameter int DATA_W = 32
) (
  input  logic [1:0]        byte_ofs,
  input  logic [2:0]        size,
  output logic [DATA_W-1:0] lane,
  output logic [4:0]        shamt,
  output logic              size_ok
);

  assign shamt = {byte_ofs, 3'b000};

  always_comb begin
    size_ok = 1'b1;
    case (size)
      3'd1:    lane = DATA_W'(32'h0000_00FF) << shamt;
      3'd2:    lane = DATA_W'(32'h0000_FFFF) << shamt;
      3'd4:    lane = '1;
      default: begin
        lane    = '0;
        size_ok = 1'b0;
      end
    endcase
  end

endmodule

// File: rtl/bridge_cfg_merge.sv
module bridge_cfg_merge
  import bridge_cfg_pkg::*;
#(
  parameter int DW = 32
) (
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] wdata,
  input  logic [DW-1:0] lane,
  input  logic [4:0]    shamt,
  input  attr_t         attr,
  output logic [DW-1:0] new_val
);

  logic [DW-1:0] wsh;
  logic [DW-1:0] rw_hit;
  logic [DW-1:0] clr_hit;

  assign wsh     = wdata << shamt;
  assign rw_hit  = attr.rw & lane;
  assign clr_hit = wsh & attr.w1c & lane;
  assign new_val = ((old_val & ~rw_hit) | (wsh & rw_hit)) & ~clr_hit;

endmodule

// File: rtl/bridge_cfg_regs.sv
module bridge_cfg_regs
  import bridge_cfg_pkg::*;
#(
  parameter int          OFS_W     = 8,
  parameter bit          PCIE_EN   = 1'b1,
  parameter bit          NO_PREF   = 1'b0,
  parameter logic [15:0] VENDOR_ID = 16'h1D0C,
  parameter logic [15:0] DEVICE_ID = 16'h0123,
  parameter logic [7:0]  REV_ID    = 8'h05
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [OFS_W-1:0]  req_offset,
  input  logic [2:0]        req_size,
  input  logic [31:0]       req_wdata,
  input  logic              sts_set_en,
  input  logic [OFS_W-3:0]  sts_set_dw,
  input  logic [31:0]       sts_set_bits,
  output logic              resp_valid,
  output logic              resp_err,
  output logic [31:0]       resp_data
);

  localparam int IDX_W    = OFS_W - 2;
  localparam int DW_N     = PCIE_EN ? (HDR_DWORDS + CAP_DWORDS) : HDR_DWORDS;
  localparam int END_BYTE = DW_N * 4;
  localparam logic [OFS_W:0] END_V = (OFS_W + 1)'(END_BYTE);

  logic [DATA_W-1:0] store  [DW_N];
  logic [DATA_W-1:0] nxt_dw [DW_N];
  attr_t             tbl    [DW_N];
  attr_t             req_attr;

  logic [IDX_W-1:0]  req_idx;
  logic              in_range;
  logic [DATA_W-1:0] lane;
  logic [4:0]        shamt;
  logic              size_ok;
  logic [DATA_W-1:0] old_val;
  logic [DATA_W-1:0] merged;
  logic              wr_go;
  logic [DATA_W-1:0] rd_masked;
  logic [DATA_W-1:0] rd_shift;
  logic [DATA_W-1:0] rd_val;

  assign req_idx  = req_offset[OFS_W-1:2];
  assign in_range = {1'b0, req_offset} < END_V;

  bridge_cfg_attr #(
    .IDX_W  (IDX_W),
    .DW_N   (DW_N),
    .PCIE_EN(PCIE_EN),
    .NO_PREF(NO_PREF)
  ) u_attr (
    .sel_idx (req_idx),
    .sel_attr(req_attr),
    .tbl     (tbl)
  );

  bridge_cfg_lane #(.DATA_W(DATA_W)) u_lane (
    .byte_ofs(req_offset[1:0]),
    .size    (req_size),
    .lane    (lane),
    .shamt   (shamt),
    .size_ok (size_ok)
  );

  always_comb begin
    old_val = '0;
    for (int i = 0; i < DW_N; i++) begin
      if (req_idx == IDX_W'(i)) old_val = store[i];
    end
  end

  bridge_cfg_merge #(.DW(DATA_W)) u_merge (
    .old_val(old_val),
    .wdata  (req_wdata),
    .lane   (lane),
    .shamt  (shamt),
    .attr   (req_attr),
    .new_val(merged)
  );

  assign wr_go = req_valid & req_write & in_range & size_ok;

  // Next value per dword: software write first, hardware set on top.
  for (genvar g = 0; g < DW_N; g++) begin : g_nxt
    always_comb begin
      nxt_dw[g] = store[g];
      if (wr_go && req_idx == IDX_W'(g)) nxt_dw[g] = merged;
      if (sts_set_en && sts_set_dw == IDX_W'(g))
        nxt_dw[g] = nxt_dw[g] | (sts_set_bits & tbl[g].w1c);
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DW_N; i++) begin
      if (rst) store[i] <= init_of(i, PCIE_EN, VENDOR_ID, DEVICE_ID, REV_ID);
      else     store[i] <= nxt_dw[i];
    end
  end

  // Read path
  assign rd_masked = old_val & (req_attr.ro | req_attr.rw | req_attr.w1c);
  assign rd_shift  = rd_masked >> shamt;

  always_comb begin
    case (req_size)
      3'd1:    rd_val = rd_shift & 32'h0000_00FF;
      3'd2:    rd_val = rd_shift & 32'h0000_FFFF;
      default: rd_val = rd_shift;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      resp_valid <= 1'b0;
      resp_err   <= 1'b0;
      resp_data  <= '0;
    end else begin
      resp_valid <= req_valid;
      resp_err   <= req_valid & in_range & ~size_ok;
      resp_data  <= (req_valid & ~req_write & in_range & size_ok) ? rd_val : '0;
    end
  end

endmodule

// File: rtl/bridge_cfg_chk.sv
module bridge_cfg_chk #(
  parameter int OFS_W   = 8,
  parameter bit PCIE_EN = 1'b1
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid,
  input logic             req_write,
  input logic [OFS_W-1:0] req_offset,
  input logic [2:0]       req_size,
  input logic             resp_valid,
  input logic             resp_err,
  input logic [31:0]      resp_data
);

  localparam int LIMIT = PCIE_EN ? 124 : 64;

  logic in_rng;
  logic good_size;
  assign in_rng    = int'(req_offset) < LIMIT;
  assign good_size = (req_size == 3'd1) || (req_size == 3'd2) || (req_size == 3'd4);

  // R2
  resp_follow_chk: assert property (@(posedge clk) disable iff (rst)
    req_valid |=> resp_valid);

  // R2
  resp_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !req_valid |=> (!resp_valid && !resp_err && resp_data == 32'h0));

  // R9
  bad_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && in_rng && !good_size) |=> (resp_err && resp_data == 32'h0));

  // R9
  good_size_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && good_size) |=> !resp_err);

  // R4
  byte_width_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 3'd1) |=> (resp_data[31:8] == 24'h0));

  // R4
  half_width_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_write && req_size == 3'd2) |=> (resp_data[31:16] == 16'h0));

  // R10
  range_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !in_rng) |=> (!resp_err && resp_data == 32'h0));

endmodule

bind bridge_cfg_regs bridge_cfg_chk #(
  .OFS_W  (OFS_W),
  .PCIE_EN(PCIE_EN)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .req_valid (req_valid),
  .req_write (req_write),
  .req_offset(req_offset),
  .req_size  (req_size),
  .resp_valid(resp_valid),
  .resp_err  (resp_err),
  .resp_data (resp_data)
);

// File: tb/sim_bridge_cfg_regs.sv
module sim_bridge_cfg_regs;

  localparam int CLK_PERIOD = 10;

  typedef struct packed {
    logic        sel;
    logic        wr;
    logic [7:0]  ofs;
    logic [2:0]  sz;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        err;
    logic [3:0]  rq;
  } vec_t;

  localparam int NV = 48;
  localparam vec_t VECS [NV] = '{
    '{1'b0,1'b0,8'h00,3'd4,32'h0,32'h01231D0C,1'b0,4'd1},  // R1
    '{1'b0,1'b0,8'h04,3'd4,32'h0,32'h00100000,1'b0,4'd1},  // R1
    '{1'b0,1'b0,8'h08,3'd4,32'h0,32'h06040005,1'b0,4'd1},  // R1
    '{1'b0,1'b0,8'h0C,3'd4,32'h0,32'h00010010,1'b0,4'd1},  // R1
    '{1'b1,1'b0,8'h0C,3'd4,32'h0,32'h00010010,1'b0,4'd1},  // R1
    '{1'b0,1'b0,8'h34,3'd4,32'h0,32'h00000040,1'b0,4'd11}, // R11
    '{1'b0,1'b0,8'h40,3'd4,32'h0,32'h00420010,1'b0,4'd11}, // R11
    '{1'b1,1'b0,8'h34,3'd4,32'h0,32'h00000000,1'b0,4'd11}, // R11
    '{1'b1,1'b0,8'h40,3'd4,32'h0,32'h00000000,1'b0,4'd10}, // R10
    '{1'b0,1'b0,8'h0E,3'd1,32'h0,32'h00000001,1'b0,4'd4},  // R4
    '{1'b0,1'b0,8'h0A,3'd2,32'h0,32'h00000604,1'b0,4'd4},  // R4
    '{1'b0,1'b0,8'h42,3'd2,32'h0,32'h00000042,1'b0,4'd4},  // R4
    '{1'b0,1'b0,8'h03,3'd1,32'h0,32'h00000001,1'b0,4'd4},  // R4
    '{1'b0,1'b1,8'h18,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd6},  // R6
    '{1'b0,1'b0,8'h18,3'd4,32'h0,32'h00FFFFFF,1'b0,4'd6},  // R6
    '{1'b0,1'b1,8'h19,3'd1,32'h00000012,32'h0,1'b0,4'd5},  // R5
    '{1'b0,1'b0,8'h18,3'd4,32'h0,32'h00FF12FF,1'b0,4'd5},  // R5
    '{1'b0,1'b0,8'h19,3'd1,32'h0,32'h00000012,1'b0,4'd5},  // R5
    '{1'b0,1'b1,8'h1C,3'd2,32'h0000FFFF,32'h0,1'b0,4'd6},  // R6
    '{1'b0,1'b0,8'h1C,3'd4,32'h0,32'h0000F0F0,1'b0,4'd6},  // R6
    '{1'b0,1'b1,8'h20,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd12}, // R12
    '{1'b0,1'b0,8'h20,3'd4,32'h0,32'hFFF0FFF0,1'b0,4'd12}, // R12
    '{1'b0,1'b1,8'h24,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd12}, // R12
    '{1'b0,1'b0,8'h24,3'd4,32'h0,32'hFFF0FFF0,1'b0,4'd12}, // R12
    '{1'b1,1'b1,8'h24,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd12}, // R12
    '{1'b1,1'b0,8'h24,3'd4,32'h0,32'h00000000,1'b0,4'd12}, // R12
    '{1'b1,1'b1,8'h28,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd12}, // R12
    '{1'b1,1'b0,8'h28,3'd4,32'h0,32'hFFFFFFFF,1'b0,4'd12}, // R12
    '{1'b0,1'b1,8'h3C,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3
    '{1'b0,1'b0,8'h3C,3'd4,32'h0,32'h004F00FF,1'b0,4'd3},  // R3
    '{1'b1,1'b1,8'h3C,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd13}, // R13
    '{1'b1,1'b0,8'h3C,3'd4,32'h0,32'h0B6F00FF,1'b0,4'd13}, // R13
    '{1'b0,1'b1,8'h04,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3
    '{1'b0,1'b0,8'h04,3'd4,32'h0,32'h00100147,1'b0,4'd3},  // R3
    '{1'b0,1'b1,8'h2C,3'd3,32'h12345678,32'h0,1'b1,4'd9},  // R9
    '{1'b0,1'b0,8'h2C,3'd4,32'h0,32'h00000000,1'b0,4'd9},  // R9
    '{1'b0,1'b0,8'h00,3'd0,32'h0,32'h00000000,1'b1,4'd9},  // R9
    '{1'b0,1'b0,8'h7C,3'd3,32'h0,32'h00000000,1'b0,4'd10}, // R10
    '{1'b0,1'b0,8'h7C,3'd4,32'h0,32'h00000000,1'b0,4'd10}, // R10
    '{1'b0,1'b1,8'h78,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3
    '{1'b0,1'b0,8'h78,3'd4,32'h0,32'h00000000,1'b0,4'd3},  // R3
    '{1'b0,1'b1,8'h70,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3
    '{1'b0,1'b0,8'h70,3'd4,32'h0,32'h0000FFFF,1'b0,4'd3},  // R3
    '{1'b1,1'b1,8'h48,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd10}, // R10
    '{1'b1,1'b0,8'h48,3'd4,32'h0,32'h00000000,1'b0,4'd10}, // R10
    '{1'b0,1'b1,8'h48,3'd4,32'hFFFFFFFF,32'h0,1'b0,4'd3},  // R3
    '{1'b0,1'b0,8'h48,3'd4,32'h0,32'h00007FFF,1'b0,4'd3},  // R3
    '{1'b0,1'b0,8'h1D,3'd2,32'h0,32'h000000F0,1'b0,4'd4}   // R4
  };

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD / 2) clk = ~clk;

  logic        a_rv, a_wr, a_se;
  logic [7:0]  a_ofs;
  logic [2:0]  a_sz;
  logic [31:0] a_wd, a_sb;
  logic [5:0]  a_sdw;
  logic        a_v, a_e;
  logic [31:0] a_d;

  logic        b_rv, b_wr, b_se;
  logic [7:0]  b_ofs;
  logic [2:0]  b_sz;
  logic [31:0] b_wd, b_sb;
  logic [5:0]  b_sdw;
  logic        b_v, b_e;
  logic [31:0] b_d;

  bridge_cfg_regs #(
    .OFS_W(8), .PCIE_EN(1'b1), .NO_PREF(1'b0),
    .VENDOR_ID(16'h1D0C), .DEVICE_ID(16'h0123), .REV_ID(8'h05)
  ) u0 (
    .clk(clk), .rst(rst), .req_valid(a_rv), .req_write(a_wr), .req_offset(a_ofs),
    .req_size(a_sz), .req_wdata(a_wd), .sts_set_en(a_se), .sts_set_dw(a_sdw),
    .sts_set_bits(a_sb), .resp_valid(a_v), .resp_err(a_e), .resp_data(a_d)
  );

  bridge_cfg_regs #(
    .OFS_W(8), .PCIE_EN(1'b0), .NO_PREF(1'b1),
    .VENDOR_ID(16'h1D0C), .DEVICE_ID(16'h0123), .REV_ID(8'h05)
  ) u1 (
    .clk(clk), .rst(rst), .req_valid(b_rv), .req_write(b_wr), .req_offset(b_ofs),
    .req_size(b_sz), .req_wdata(b_wd), .sts_set_en(b_se), .sts_set_dw(b_sdw),
    .sts_set_bits(b_sb), .resp_valid(b_v), .resp_err(b_e), .resp_data(b_d)
  );

  int checks   = 0;
  int failures = 0;
  bit done     = 1'b0;

  logic        got_v, got_e;
  logic [31:0] got_d;

  task automatic check(input bit ok, input string rq, input logic [31:0] act,
                       input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%08h expected=%08h", rq, act, exp);
    end
  endtask

  // One clock of stimulus on the selected copy, response sampled a clock later.
  task automatic cyc(input bit sel, input bit rv, input bit wr, input logic [7:0] ofs,
                     input logic [2:0] sz, input logic [31:0] wd, input bit se,
                     input logic [5:0] sdw, input logic [31:0] sb);
    @(negedge clk);
    if (!sel) begin
      a_rv = rv; a_wr = wr; a_ofs = ofs; a_sz = sz; a_wd = wd;
      a_se = se; a_sdw = sdw; a_sb = sb;
    end else begin
      b_rv = rv; b_wr = wr; b_ofs = ofs; b_sz = sz; b_wd = wd;
      b_se = se; b_sdw = sdw; b_sb = sb;
    end
    @(negedge clk);
    got_v = sel ? b_v : a_v;
    got_e = sel ? b_e : a_e;
    got_d = sel ? b_d : a_d;
    a_rv = 1'b0; a_se = 1'b0; b_rv = 1'b0; b_se = 1'b0;
  endtask

  task automatic rd(input bit sel, input logic [7:0] ofs, input logic [31:0] exp,
                    input string rq);
    cyc(sel, 1'b1, 1'b0, ofs, 3'd4, 32'h0, 1'b0, 6'd0, 32'h0);
    check(got_v && !got_e && got_d == exp, rq, got_d, exp);
  endtask

  task automatic wr(input bit sel, input logic [7:0] ofs, input logic [2:0] sz,
                    input logic [31:0] wd);
    cyc(sel, 1'b1, 1'b1, ofs, sz, wd, 1'b0, 6'd0, 32'h0);
  endtask

  task automatic sset(input bit sel, input logic [5:0] dw, input logic [31:0] bits);
    cyc(sel, 1'b0, 1'b0, 8'h0, 3'd4, 32'h0, 1'b1, dw, bits);
  endtask

  initial begin
    a_rv = 0; a_wr = 0; a_ofs = 0; a_sz = 0; a_wd = 0; a_se = 0; a_sdw = 0; a_sb = 0;
    b_rv = 0; b_wr = 0; b_ofs = 0; b_sz = 0; b_wd = 0; b_se = 0; b_sdw = 0; b_sb = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 / R2: idle outputs after reset
    check(!a_v && !a_e && a_d == 32'h0, "R2 reset idle u0", a_d, 32'h0);
    check(!b_v && !b_e && b_d == 32'h0, "R2 reset idle u1", b_d, 32'h0);

    for (int i = 0; i < NV; i++) begin
      cyc(VECS[i].sel, 1'b1, VECS[i].wr, VECS[i].ofs, VECS[i].sz, VECS[i].wd,
          1'b0, 6'd0, 32'h0);
      checks++;
      if (!(got_v && got_e == VECS[i].err && got_d == VECS[i].exp)) begin
        failures++;
        $display("FAIL R%0d vec %0d actual=%08h err=%0b expected=%08h err=%0b",
                 VECS[i].rq, i, got_d, got_e, VECS[i].exp, VECS[i].err);
      end
    end

    // R2: no response after an idle clock
    @(negedge clk);
    check(!a_v && a_d == 32'h0, "R2 idle pulse low", {31'h0, a_v}, 32'h0);

    // R8: hardware event raises only W1C bits of 0x1C
    sset(1'b0, 6'd7, 32'hFFFFFFFF);
    rd(1'b0, 8'h1C, 32'hF900F0F0, "R8 set only w1c");
    // R7: zero data leaves bits
    wr(1'b0, 8'h1F, 3'd1, 32'h00);
    rd(1'b0, 8'h1C, 32'hF900F0F0, "R7 write zero");
    // R7: ones outside the lane leave bits
    wr(1'b0, 8'h1E, 3'd1, 32'hFF);
    rd(1'b0, 8'h1C, 32'hF900F0F0, "R7 outside lane");
    // R7: ones inside the lane clear
    wr(1'b0, 8'h1F, 3'd1, 32'h81);
    rd(1'b0, 8'h1C, 32'h7800F0F0, "R7 clear bits");
    wr(1'b0, 8'h1C, 3'd4, 32'h78000000);
    rd(1'b0, 8'h1C, 32'h00000000, "R7 clear rest");
    // R8: set wins over a same-cycle clear
    cyc(1'b0, 1'b1, 1'b1, 8'h1F, 3'd1, 32'h80, 1'b1, 6'd7, 32'h80000000);
    rd(1'b0, 8'h1C, 32'h80000000, "R8 set beats clear");
    // R8: dword with no W1C bits is untouched
    sset(1'b0, 6'd3, 32'hFFFFFFFF);
    rd(1'b0, 8'h0C, 32'h00010010, "R8 no w1c dword");
    // R13: bridge-control bit 26 without capability
    sset(1'b1, 6'd15, 32'h04000000);
    rd(1'b1, 8'h3C, 32'h0F6F00FF, "R13 bit26 set");
    wr(1'b1, 8'h3E, 3'd2, 32'h0400);
    rd(1'b1, 8'h3C, 32'h000000FF, "R13 bit26 clear");
    // R13: bit 26 reserved with capability
    sset(1'b0, 6'd15, 32'h04000000);
    rd(1'b0, 8'h3C, 32'h004F00FF, "R13 bit26 reserved");
    // R9: bad size write left 0x2C unchanged on u1 as well
    wr(1'b1, 8'h2C, 3'd3, 32'hFFFFFFFF);
    check(got_e, "R9 err flag u1", {31'h0, got_e}, 32'h1);
    rd(1'b1, 8'h2C, 32'h00000000, "R9 no change u1");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule